// File: doc/BRIEF.md
# Bridge System Error Aggregator

This block gathers the system error conditions of a two-port bus bridge and turns them into the active-low system error output on the upstream bus. Seven event strobes arrive from the transaction engines, one bit each, and the downstream bus's own active-low system error input arrives as a level. Each source passes through its own gate. Six events have a bit in a disable register. Master timeout is gated by its own enable in the bridge-control register. Downstream forwarding has a forward enable. A global error enable in the command register gates everything.

When a qualifying condition is present, the upstream output is driven low for one clock. The block also records the cause in a sticky reason register and sets the signaled-error bit in the primary status. Forwarded downstream errors set the received-error bit in the secondary status. Software reads the registers and clears the status bits with a write-one-to-clear port. The retry counters that produce the three "dropped after the retry limit" strobes sit outside this block. Those counters give up after 2^24 delivery attempts by default.

Top module: `sys_err_aggr`

## Requirements
- R1: While the error enable (control register, address 0, bit 0) is 0, `up_err_n` stays 1 and no reason or status bit is set, whatever the inputs.
- R2: Every clock in which `up_err_n` is 0, the signaled-error bit (address 3, bit 0) reads 1.
- R3: When `dn_err_n` is 0 in a cycle while the forward enable (address 0, bit 1) and the error enable are 1, `up_err_n` is 0 in the next cycle. The received-error bit (address 3, bit 1) is also set. With the forward enable at 0, a low `dn_err_n` has no effect.
- R4: Events 0 to 5 each have a disable bit at the same position of the disable register (address 1, bits 5:0). The events are: 0 target abort on posted write, 1 master abort on posted write, 2 posted write dropped at retry limit, 3 parity error reported on posted write, 4 delayed write dropped at retry limit, 5 delayed read not delivered at retry limit. A clear disable bit lets that event assert the output.
- R5: Event 6 (master timeout on a delayed transaction) has no disable bit. It is gated only by the master-timeout enable (address 0, bit 2). Writing disable bits never affects it.
- R6: A qualifying event i sets reason bit i (address 2, bits 6:0) at the same edge at which `up_err_n` goes low.
- R7: `up_err_n` is 0 in exactly those clocks that follow a clock with at least one qualifying condition. Simultaneous conditions give a single one-clock assertion.
- R8: Reason and status bits are sticky. Writing 1 to a bit position at address 2 or 3 clears it. If a new set arrives in the same cycle as the clear, the set wins.
- R9: A disabled or ungated event sets no reason bit and no signaled-error bit.
- R10: A synchronous active-low reset clears every enable, disable bit, reason bit and status bit to 0 and drives `up_err_n` to 1.
- R11: Register reads are combinational from `reg_addr`. Control bits sit at address 0 bits 2:0, disable bits at address 1 bits 5:0, reason bits at address 2 bits 6:0 and status bits at address 3 bits 1:0. All other bits read 0. Writes to addresses 0 and 1 replace the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| evt | input | 7 | One-cycle event strobes, bit index per R4/R5 |
| dn_err_n | input | 1 | Downstream system error input, active low |
| up_err_n | output | 1 | Upstream system error output, active low |

## Verification
The hardest case to reach is a clear that meets a new set in the same cycle. The write-one-to-clear must land exactly on the edge where a qualifying event re-sets the same reason bit. The bench gets there with a directed write to the reason register that carries the matching event strobe in the same cycle. Random stimulus then keeps mixing writes with event strobes so that further collisions happen in every mask and enable setting. The master-timeout path is exercised with all disable bits set and the timeout enable off, and then with the enable on. This shows that the disable register never reaches event 6.

// File: rtl/sys_err_aggr.sv
module sys_err_aggr #(
  parameter int NEVT = 7,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NEVT-1:0] evt,
  input  logic          dn_err_n,
  output logic          up_err_n
);
  localparam int NDIS = NEVT - 1;

  logic            en, fwd_en, mto_en;
  logic [NDIS-1:0] dis;
  logic [NEVT-1:0] rsn;
  logic            sig, rcv;
  logic [NEVT-1:0] qual;
  logic            fwd, fire;

  assign qual = {evt[NEVT-1] & mto_en, evt[NDIS-1:0] & ~dis} & {NEVT{en}};
  assign fwd  = en & fwd_en & ~dn_err_n;
  assign fire = |qual | fwd;

  wire wr_ctl = reg_we && reg_addr == 2'd0;
  wire wr_dis = reg_we && reg_addr == 2'd1;
  wire wr_rsn = reg_we && reg_addr == 2'd2;
  wire wr_sts = reg_we && reg_addr == 2'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; fwd_en <= 1'b0; mto_en <= 1'b0;
      dis <= '0; rsn <= '0; sig <= 1'b0; rcv <= 1'b0;
      up_err_n <= 1'b1;
    end else begin
      if (wr_ctl) {mto_en, fwd_en, en} <= reg_wdata[2:0];
      if (wr_dis) dis <= reg_wdata[NDIS-1:0];
      rsn <= (rsn & ~(wr_rsn ? reg_wdata[NEVT-1:0] : '0)) | qual;
      sig <= (sig & ~(wr_sts & reg_wdata[0])) | fire;
      rcv <= (rcv & ~(wr_sts & reg_wdata[1])) | fwd;
      up_err_n <= ~fire;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      2'd0: reg_rdata[2:0] = {mto_en, fwd_en, en};
      2'd1: reg_rdata[NDIS-1:0] = dis;
      2'd2: reg_rdata[NEVT-1:0] = rsn;
      2'd3: reg_rdata[1:0] = {rcv, sig};
    endcase
  end
endmodule

module sys_err_aggr_chk #(
  parameter int NEVT = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            up_err_n,
  input logic            dn_err_n,
  input logic            en,
  input logic            fwd_en,
  input logic            mto_en,
  input logic [NEVT-2:0] dis,
  input logic [NEVT-1:0] rsn,
  input logic            sig,
  input logic            rcv
);
  // R1
  no_fire_wo_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> up_err_n);
  // R2
  sig_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_err_n |-> sig);
  // R3
  fwd_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fwd_en && !dn_err_n) |=> (!up_err_n && rcv));
  // R5
  mto_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsn[NEVT-1]) |-> ($past(mto_en) && $past(en)));
  // R9
  dis_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsn[0]) |-> (!$past(dis[0]) && $past(en)));
  // R6
  rsn_with_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsn[1]) |-> !up_err_n);
endmodule

bind sys_err_aggr sys_err_aggr_chk #(.NEVT(NEVT)) chk_i (
  .clk(clk), .rst_n(rst_n), .up_err_n(up_err_n), .dn_err_n(dn_err_n),
  .en(en), .fwd_en(fwd_en), .mto_en(mto_en), .dis(dis), .rsn(rsn),
  .sig(sig), .rcv(rcv)
);

// File: tb/sys_err_aggr_tb_top.sv
`timescale 1ns/100ps
module sys_err_aggr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [6:0] evt = '0;
  logic dn_err_n = 1'b1, up_err_n;

  int checks = 0, errors = 0;
  logic [2:0] m_ctl = '0;
  logic [5:0] m_dis = '0;
  logic [6:0] m_rsn = '0;
  logic [1:0] m_sts = '0;
  bit done = 0;

  always #4 clk = ~clk;

  sys_err_aggr dut_i (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {5'd0, m_ctl};
      2'd1: return {2'd0, m_dis};
      2'd2: return {1'b0, m_rsn};
      default: return {6'd0, m_sts};
    endcase
  endfunction

  function automatic logic [6:0] exp_qual(input logic [6:0] e);
    return ({e[6] & m_ctl[2], e[5:0] & ~m_dis}) & {7{m_ctl[0]}};
  endfunction

  task automatic cyc(input string tag, input logic we, input logic [1:0] a,
                     input logic [7:0] d, input logic [6:0] e, input logic dn);
    logic [6:0] q;
    logic f, fw;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; evt = e; dn_err_n = dn;
    q  = exp_qual(e);
    fw = m_ctl[0] & m_ctl[1] & ~dn;
    f  = (|q) | fw;
    @(posedge clk); #1;
    if (we && a == 2'd0) m_ctl = d[2:0];
    if (we && a == 2'd1) m_dis = d[5:0];
    m_rsn = (m_rsn & ~((we && a == 2'd2) ? d[6:0] : 7'd0)) | q;
    m_sts[0] = (m_sts[0] & ~(we && a == 2'd3 && d[0])) | f;
    m_sts[1] = (m_sts[1] & ~(we && a == 2'd3 && d[1])) | fw;
    chk({tag, " R7 out"}, {7'd0, up_err_n}, {7'd0, ~f});
  endtask

  task automatic read_all(input string tag);
    @(negedge clk);
    reg_we = 0; evt = '0; dn_err_n = 1;
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0]; #0.5;
      chk({tag, " R11 read"}, reg_rdata, exp_rd(a[1:0]));
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc("wr", 1'b1, a, d, 7'd0, 1'b1);
  endtask

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    chk("R10 out at reset", {7'd0, up_err_n}, 8'd1);
    @(negedge clk); rst_n = 1;
    read_all("R10");
    // R1: all disabled
    cyc("R1", 0, 0, 0, 7'h7F, 1'b0);
    cyc("R1", 0, 0, 0, 7'h00, 1'b1);
    read_all("R1");
    // R5 / R4 / R6 / R2
    wr(0, 8'h01);
    wr(1, 8'h3F);
    cyc("R5 mto off", 0, 0, 0, 7'h40, 1'b1);
    wr(0, 8'h05);
    cyc("R5 mto on, all dis set", 0, 0, 0, 7'h40, 1'b1);
    read_all("R5");
    chk("R5 reason bit6", {1'b0, m_rsn}, 8'h40);
    wr(1, 8'h00);
    cyc("R4 evt0", 0, 0, 0, 7'h01, 1'b1);
    read_all("R6 R2");
    // R9: disabled event 3
    wr(2, 8'h7F); wr(3, 8'h03);
    wr(1, 8'h08);
    cyc("R9 dis evt3", 0, 0, 0, 7'h08, 1'b1);
    read_all("R9");
    // R7: simultaneous events single pulse
    wr(1, 8'h00);
    cyc("R7 multi", 0, 0, 0, 7'h37, 1'b1);
    cyc("R7 after", 0, 0, 0, 7'h00, 1'b1);
    read_all("R7");
    // R8: clear collides with set
    cyc("R8 clr+set", 1, 2, 8'h01, 7'h01, 1'b1);
    read_all("R8 set wins");
    cyc("R8 clr", 1, 2, 8'h7F, 7'h00, 1'b1);
    cyc("R8 sts clr", 1, 3, 8'h03, 7'h00, 1'b1);
    read_all("R8 cleared");
    // R3 forwarding
    cyc("R3 fwd off", 0, 0, 0, 7'h00, 1'b0);
    read_all("R3 off");
    wr(0, 8'h03);
    cyc("R3 fwd on", 0, 0, 0, 7'h00, 1'b0);
    cyc("R3 fwd held", 0, 0, 0, 7'h00, 1'b0);
    read_all("R3 on");
    // random
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [7:0] d;
      we = ($urandom % 8) == 0;
      d = 8'($urandom);
      if (we && ($urandom % 4) == 0) d = 8'h01 | d;
      cyc("rand", we, 2'($urandom), d, 7'($urandom) & 7'($urandom), ($urandom % 6) != 0);
      if (i % 50 == 49) read_all("rand");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule